// File: doc/BRIEF.md
# SM3 Block Compression Engine

This engine applies the SM3 compression function to one 512-bit message block each time it is started. It holds a 256-bit chaining value made of eight 32-bit words, A in the top word down to H in the bottom word. While a block is running, it takes one expanded word pair per round from an external expansion unit. Each pair is the word Wj together with its companion W'j = Wj xor Wj+4, and it arrives over a valid/ready handshake. The engine generates the round constant itself and advances one round per accepted pair, so it finishes a block in 64 accepted transfers.

Once the last round is done, the working words are folded back into the chaining value with XOR, and a single-cycle done pulse is raised. The chaining value persists across starts, which lets a long message be hashed block after block without software involvement. A load input sets a new initial value before the first block. Padding, length encoding and byte buffering belong to the surrounding logic.

Top module: `sm3_compress`

## Requirements
- R1: After reset, `digest` holds the standard SM3 initial value 7380166f 4914b2b9 172442d7 da8a0600 a96f30bc 163138aa e38dee4d b0fb0e4e, with word A in bits 255:224 and word H in bits 31:0. `done` and `w_ready` are low.
- R2: When the engine is idle and `start` is low, a `load_iv` high at a clock edge copies `iv` into the chaining value, using the same word layout as R1. The new value appears on `digest` after that edge.
- R3: When the engine is idle, a `start` high at a clock edge begins a block. The block uses the chaining value present before that edge, and any `load_iv` in the same cycle is ignored. `w_ready` is high from the next cycle until the 64th pair is accepted.
- R4: A block consumes exactly 64 word pairs. `done` is high for exactly the one cycle after the 64th pair is accepted, and `w_ready` is low in that cycle.
- R5: A cycle with `w_ready` high and `w_valid` low advances no round. The resulting digest does not depend on the valid pattern.
- R6: Each round computes SS1 = rotl(rotl(A,12)+E+Tj,7), SS2 = SS1 xor rotl(A,12), TT1 = FF+D+SS2+W'j and TT2 = GG+H+SS1+Wj, all modulo 2^32. It then shifts the words: A gets TT1, B gets A, C gets rotl(B,9), D gets C, E gets P0(TT2), F gets E, G gets rotl(F,19), H gets G. Here P0(x) = x xor rotl(x,9) xor rotl(x,17).
- R7: In rounds 0 to 15, FF and GG are both the three-way XOR. From round 16 on, FF is bitwise majority and GG is bitwise choose (x&y)|(~x&z).
- R8: The round constant Tj is rotl(79cc4519h, j) for j below 16, and rotl(7a879d8ah, j mod 32) from round 16 on.
- R9: In the done cycle, `digest` shows the old chaining value XOR the final A..H. It does not change at any other time except through R2.
- R10: A following start continues from the digest produced by the previous block.
- R11: While a block is running, `start` and `load_iv` have no effect on the block or on the chaining value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_iv | input | 1 | Load `iv` into the chaining value when idle |
| iv | input | 256 | Initial chaining value, A in the top word |
| start | input | 1 | Begin compressing one block when idle |
| w_valid | input | 1 | Word pair on `w_word`/`wp_word` is valid |
| w_ready | output | 1 | Engine accepts a word pair this cycle |
| w_word | input | 32 | Expanded word Wj for the current round |
| wp_word | input | 32 | Companion word W'j for the current round |
| digest | output | 256 | Current chaining value |
| done | output | 1 | One-cycle pulse when a block completes |

## Verification
The bench runs a reference model alongside the engine and compares `w_ready`, `done` and `digest` on every cycle. It also checks the published digest of the padded message "abc". That known vector exposes several kinds of error: boolean functions that switch a round early or late, a wrong constant base or rotation, or a feed-forward done with addition instead of XOR. Any of these yields a different 256-bit result.

Runs with pseudo-random gaps in `w_valid` would catch a design that advances its round counter or constant on a stalled cycle: it would skip or repeat a round and the digest would diverge. A second chained block confirms that the next block starts from the updated digest. A run that pulses `start` and `load_iv` mid-block shows whether either one disturbs the chaining value or restarts the round count.

// File: rtl/sm3_pkg.sv
package sm3_pkg;
   localparam int WORD_W       = 32;
   localparam int NUM_WORDS    = 8;
   localparam int STATE_W      = WORD_W * NUM_WORDS;
   localparam int ROUNDS       = 64;
   localparam int SWITCH_ROUND = 16;
   localparam int RND_W        = $clog2(ROUNDS);
   localparam int ROT_W        = $clog2(WORD_W);

   localparam logic [WORD_W-1:0] T_LOW  = 32'h79cc4519;
   localparam logic [WORD_W-1:0] T_HIGH = 32'h7a879d8a;

   typedef logic [WORD_W-1:0] word_t;

   typedef struct packed {
      word_t a;
      word_t b;
      word_t c;
      word_t d;
      word_t e;
      word_t f;
      word_t g;
      word_t h;
   } sm3_state_t;

   function automatic word_t rotl(word_t x, int n);
      int m;
      m = n % WORD_W;
      if (m == 0) return x;
      return (x << m) | (x >> (WORD_W - m));
   endfunction

   function automatic word_t p0(word_t x);
      return x ^ rotl(x, 9) ^ rotl(x, 17);
   endfunction
endpackage

// File: rtl/sm3_ctrl.sv
module sm3_ctrl
   import sm3_pkg::*;
#(
   parameter int N_ROUNDS = ROUNDS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             valid_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             begin_o,
   output logic             step_o,
   output logic             last_o,
   output logic [RND_W-1:0] rnd_o
);
   localparam logic [RND_W-1:0] LAST_RND = RND_W'(N_ROUNDS - 1);

   if (N_ROUNDS < 2 || N_ROUNDS > (1 << RND_W)) begin : g_bad_rounds
      $error("sm3_ctrl: N_ROUNDS out of range");
   end

   logic             busy_q;
   logic             done_q;
   logic [RND_W-1:0] rnd_q;

   assign begin_o = start_i && !busy_q;
   assign step_o  = busy_q && valid_i;
   assign last_o  = (rnd_q == LAST_RND);
   assign busy_o  = busy_q;
   assign done_o  = done_q;
   assign rnd_o   = rnd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         rnd_q  <= '0;
      end else begin
         done_q <= step_o && last_o;
         if (begin_o) begin
            busy_q <= 1'b1;
            rnd_q  <= '0;
         end else if (step_o) begin
            if (last_o) begin
               busy_q <= 1'b0;
               rnd_q  <= '0;
            end else begin
               rnd_q <= rnd_q + 1'b1;
            end
         end
      end
   end

   // R4: each accepted pair moves exactly one round forward
   assert_round_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step_o && !last_o) |=> (rnd_q == $past(rnd_q) + 1'b1));

   // R4: done lasts a single cycle
   assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R4: done only follows acceptance of the final pair
   assert_done_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> $past(step_o && last_o));

   // R5: a stalled cycle keeps the round index
   assert_hold_on_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !valid_i) |=> (busy_q && $stable(rnd_q)));
endmodule

// File: rtl/sm3_const_gen.sv
module sm3_const_gen
   import sm3_pkg::*;
#(
   parameter int CONST_STYLE = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             busy_i,
   input  logic             begin_i,
   input  logic             step_i,
   input  logic [RND_W-1:0] rnd_i,
   output word_t            k_o
);
   localparam logic [RND_W-1:0] HAND_OVER = RND_W'(SWITCH_ROUND - 1);
   localparam logic [RND_W-1:0] SWITCH_AT = RND_W'(SWITCH_ROUND);

   if (CONST_STYLE == 0) begin : g_barrel
      logic unused_const_ins;
      assign unused_const_ins = ^{clk, rst_n, busy_i, begin_i, step_i};
      assign k_o = rotl((rnd_i >= SWITCH_AT) ? T_HIGH : T_LOW, int'(rnd_i[ROT_W-1:0]));
   end else if (CONST_STYLE == 1) begin : g_step
      word_t k_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            k_q <= T_LOW;
         end else if (begin_i) begin
            k_q <= T_LOW;
         end else if (step_i) begin
            if (rnd_i == HAND_OVER) k_q <= rotl(T_HIGH, SWITCH_ROUND);
            else                    k_q <= rotl(k_q, 1);
         end
      end
      assign k_o = k_q;

      // R8: stepped register agrees with the rotated base for the live round
      assert_const_sched_R8: assert property (@(posedge clk) disable iff (!rst_n)
         busy_i |-> (k_q == rotl((rnd_i >= SWITCH_AT) ? T_HIGH : T_LOW,
                                 int'(rnd_i[ROT_W-1:0]))));
   end else begin : g_bad_style
      $error("sm3_const_gen: CONST_STYLE must be 0 or 1");
   end
endmodule

// File: rtl/sm3_round.sv
module sm3_round
   import sm3_pkg::*;
(
   input  sm3_state_t s_i,
   input  word_t      w_i,
   input  word_t      wp_i,
   input  word_t      k_i,
   input  logic       late_i,
   output sm3_state_t s_o
);
   word_t a_rot, ss1, ss2, ff_v, gg_v, tt1, tt2;

   always_comb begin
      a_rot = rotl(s_i.a, 12);
      ss1   = rotl(a_rot + s_i.e + k_i, 7);
      ss2   = ss1 ^ a_rot;
      if (late_i) begin
         ff_v = (s_i.a & s_i.b) | (s_i.a & s_i.c) | (s_i.b & s_i.c);
         gg_v = (s_i.e & s_i.f) | (~s_i.e & s_i.g);
      end else begin
         ff_v = s_i.a ^ s_i.b ^ s_i.c;
         gg_v = s_i.e ^ s_i.f ^ s_i.g;
      end
      tt1 = ff_v + s_i.d + ss2 + wp_i;
      tt2 = gg_v + s_i.h + ss1 + w_i;
      s_o.a = tt1;
      s_o.b = s_i.a;
      s_o.c = rotl(s_i.b, 9);
      s_o.d = s_i.c;
      s_o.e = p0(tt2);
      s_o.f = s_i.e;
      s_o.g = rotl(s_i.f, 19);
      s_o.h = s_i.g;
   end
endmodule

// File: rtl/sm3_compress.sv
module sm3_compress
   import sm3_pkg::*;
#(
   parameter int                 CONST_STYLE = 1,
   parameter logic [STATE_W-1:0] DEFAULT_IV  =
      256'h7380166f_4914b2b9_172442d7_da8a0600_a96f30bc_163138aa_e38dee4d_b0fb0e4e
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_iv,
   input  logic [STATE_W-1:0] iv,
   input  logic               start,
   input  logic               w_valid,
   output logic               w_ready,
   input  logic [WORD_W-1:0]  w_word,
   input  logic [WORD_W-1:0]  wp_word,
   output logic [STATE_W-1:0] digest,
   output logic               done
);
   localparam logic [RND_W-1:0] SWITCH_AT = RND_W'(SWITCH_ROUND);

   logic               busy_s, begin_s, step_s, last_s;
   logic [RND_W-1:0]   rnd_s;
   word_t              k_s;
   logic [STATE_W-1:0] chain_q;
   sm3_state_t         work_q, round_out;

   sm3_ctrl #(.N_ROUNDS(ROUNDS)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(start),
      .valid_i(w_valid),
      .busy_o (busy_s),
      .done_o (done),
      .begin_o(begin_s),
      .step_o (step_s),
      .last_o (last_s),
      .rnd_o  (rnd_s)
   );

   sm3_const_gen #(.CONST_STYLE(CONST_STYLE)) u_kgen (
      .clk    (clk),
      .rst_n  (rst_n),
      .busy_i (busy_s),
      .begin_i(begin_s),
      .step_i (step_s),
      .rnd_i  (rnd_s),
      .k_o    (k_s)
   );

   sm3_round u_round (
      .s_i   (work_q),
      .w_i   (w_word),
      .wp_i  (wp_word),
      .k_i   (k_s),
      .late_i(rnd_s >= SWITCH_AT),
      .s_o   (round_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= DEFAULT_IV;
         work_q  <= '0;
      end else begin
         if (begin_s)     work_q <= chain_q;
         else if (step_s) work_q <= round_out;
         if (step_s && last_s)                  chain_q <= chain_q ^ round_out;
         else if (!busy_s && !start && load_iv) chain_q <= iv;
      end
   end

   assign w_ready = busy_s;
   assign digest  = chain_q;

   // R5: working words hold while the pair is missing
   assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (w_ready && !w_valid) |=> $stable(work_q));

   // R11: chaining value frozen during a block until the final round
   assert_chain_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (w_ready && !(w_valid && last_s)) |=> $stable(digest));

   // R4: engine is not accepting in the done cycle
   assert_done_not_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !w_ready);

   // R3: a block start raises ready on the next cycle
   assert_start_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !w_ready) |=> w_ready);
endmodule

// File: tb/sm3_compress_bench.sv
module sm3_compress_bench;
   localparam int CLK_NS = 10;
   localparam logic [255:0] STD_IV =
      256'h7380166f_4914b2b9_172442d7_da8a0600_a96f30bc_163138aa_e38dee4d_b0fb0e4e;
   localparam logic [255:0] ABC_DIGEST =
      256'h66c7f0f4_62eeedd9_d1f2d46b_dc10e4e2_4167c487_5cf2f7a2_297da02b_8f4ba8e0;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         load_iv = 1'b0;
   logic [255:0] iv = '0;
   logic         start = 1'b0;
   logic         w_valid = 1'b0;
   logic [31:0]  w_word = '0;
   logic [31:0]  wp_word = '0;
   logic         w_ready;
   logic [255:0] digest;
   logic         done;

   int total = 0;
   int bad = 0;

   logic [31:0]  msg [16];
   logic [31:0]  wexp [68];
   logic [15:0]  lfsr = 16'hace1;

   bit           m_busy = 1'b0;
   bit           m_done = 1'b0;
   int           m_rnd = 0;
   int           feed = 0;
   logic [255:0] m_chain = STD_IV;
   logic [255:0] m_result = '0;

   always #(CLK_NS/2) clk = ~clk;

   sm3_compress u_sm3_compress (
      .clk(clk), .rst_n(rst_n), .load_iv(load_iv), .iv(iv), .start(start),
      .w_valid(w_valid), .w_ready(w_ready), .w_word(w_word), .wp_word(wp_word),
      .digest(digest), .done(done)
   );

   function automatic logic [31:0] rl(logic [31:0] x, int n);
      int m;
      m = n % 32;
      if (m == 0) return x;
      return (x << m) | (x >> (32 - m));
   endfunction

   function automatic void expand();
      logic [31:0] x;
      for (int j = 0; j < 16; j++) wexp[j] = msg[j];
      for (int j = 16; j < 68; j++) begin
         x = wexp[j-16] ^ wexp[j-9] ^ rl(wexp[j-3], 15);
         wexp[j] = x ^ rl(x, 15) ^ rl(x, 23) ^ rl(wexp[j-13], 7) ^ wexp[j-6];
      end
   endfunction

   function automatic logic [255:0] ref_block(logic [255:0] v);
      logic [31:0] r [8];
      logic [31:0] tj, s1, s2, f1, g1, t1, t2;
      logic [255:0] res;
      for (int i = 0; i < 8; i++) r[i] = v[255 - 32*i -: 32];
      for (int j = 0; j < 64; j++) begin
         tj = rl((j < 16) ? 32'h79cc4519 : 32'h7a879d8a, j % 32);
         s1 = rl(rl(r[0], 12) + r[4] + tj, 7);
         s2 = s1 ^ rl(r[0], 12);
         f1 = (j < 16) ? (r[0] ^ r[1] ^ r[2]) : ((r[0] & r[1]) | (r[0] & r[2]) | (r[1] & r[2]));
         g1 = (j < 16) ? (r[4] ^ r[5] ^ r[6]) : ((r[4] & r[5]) | (~r[4] & r[6]));
         t1 = f1 + r[3] + s2 + (wexp[j] ^ wexp[j+4]);
         t2 = g1 + r[7] + s1 + wexp[j];
         r[3] = r[2]; r[2] = rl(r[1], 9); r[1] = r[0]; r[0] = t1;
         r[7] = r[6]; r[6] = rl(r[5], 19); r[5] = r[4];
         r[4] = t2 ^ rl(t2, 9) ^ rl(t2, 17);
      end
      for (int i = 0; i < 8; i++) res[255 - 32*i -: 32] = r[i];
      return res ^ v;
   endfunction

   task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive_words();
      if (feed < 64) begin
         w_word  = wexp[feed];
         wp_word = wexp[feed] ^ wexp[feed+4];
      end
   endtask

   // one clock: model update at the edge, compare at the falling edge
   task automatic cycle();
      @(posedge clk);
      m_done = 1'b0;
      if (m_busy) begin
         if (w_valid) begin
            feed++;
            if (m_rnd == 63) begin
               m_busy  = 1'b0;
               m_done  = 1'b1;
               m_chain = m_result;
            end else begin
               m_rnd++;
            end
         end
      end else if (start) begin
         m_busy   = 1'b1;
         m_rnd    = 0;
         m_result = ref_block(m_chain);
      end else if (load_iv) begin
         m_chain = iv;
      end
      @(negedge clk);
      check("R3 ready", {255'd0, w_ready}, {255'd0, m_busy});
      check("R4 done", {255'd0, done}, {255'd0, m_done});
      check("R9 digest", digest, m_chain);
      drive_words();
   endtask

   task automatic run_block(input int stall, input bit poke, input logic [255:0] junk);
      expand();
      feed = 0;
      drive_words();
      start = 1'b1;
      cycle();
      start = 1'b0;
      for (int c = 0; c < 3000 && !m_done; c++) begin
         w_valid = (stall == 0) ? 1'b1 : (lfsr[0] | lfsr[3]);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (poke && (c == 20 || c == 45)) begin
            start = 1'b1; load_iv = 1'b1; iv = junk;
         end else begin
            start = 1'b0; load_iv = 1'b0;
         end
         cycle();
      end
      w_valid = 1'b0; start = 1'b0; load_iv = 1'b0;
   endtask

   task automatic load_value(input logic [255:0] v);
      iv = v; load_iv = 1'b1;
      cycle();
      load_iv = 1'b0;
   endtask

   task automatic set_abc();
      for (int i = 0; i < 16; i++) msg[i] = 32'h0;
      msg[0]  = 32'h61626380;
      msg[15] = 32'h00000018;
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(CLK_NS * 150000);
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      logic [255:0] prev;
      logic [255:0] exp_v;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      check("R1 digest", digest, STD_IV);
      check("R1 done", {255'd0, done}, 256'd0);
      check("R1 ready", {255'd0, w_ready}, 256'd0);

      // R2: loading while idle
      load_value(256'h01234567_89abcdef_fedcba98_76543210_0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0);
      check("R2 loaded", digest,
            256'h01234567_89abcdef_fedcba98_76543210_0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0);
      load_value(STD_IV);
      check("R2 reload", digest, STD_IV);

      // R6 R7 R8: known vector, no stalls
      set_abc();
      run_block(0, 1'b0, '0);
      check("R6 R7 R8 abc vector", digest, ABC_DIGEST);

      // R5: same block with gaps in valid
      load_value(STD_IV);
      run_block(1, 1'b0, '0);
      check("R5 stalled abc vector", digest, ABC_DIGEST);

      // R10: second block chains from previous digest
      prev = digest;
      for (int i = 0; i < 16; i++) msg[i] = (32'h01010101 * i) ^ 32'ha5a5a5a5;
      expand();
      exp_v = ref_block(prev);
      run_block(1, 1'b0, '0);
      check("R10 chained block", digest, exp_v);

      // R11: start and load_iv mid-block are ignored
      load_value(STD_IV);
      set_abc();
      run_block(0, 1'b1, {8{32'hdeadbeef}});
      check("R11 pokes ignored", digest, ABC_DIGEST);

      // R3: block uses the chaining value present at start
      load_value({8{32'h5a5aa5a5}});
      set_abc();
      expand();
      exp_v = ref_block({8{32'h5a5aa5a5}});
      run_block(1, 1'b0, '0);
      check("R3 start from loaded value", digest, exp_v);

      repeat (2) cycle();
      finish_run();
   end
endmodule